// File: doc/BRIEF.md
# Timely Offset Prefetch Selector

This block sits next to a second-level cache and watches two streams of events: read accesses (each tagged as a miss or as a hit on a line that arrived by prefetch) and line fills (each tagged as prefetched or demand). For every eligible access to line X it may ask for one prefetch of line X+D. D is the current offset, and the request is only made when X+D stays inside the 4 KB page of X. The offset is not fixed. The block keeps learning it by scoring a constant list of candidate offsets against a small direct-mapped table. That table records the base lines of prefetches that have already completed.

A candidate d earns a point when X−d is found in that table. Such a hit means that a prefetch started from X−d had time to finish before X was wanted. The block therefore rewards offsets that give timely prefetches, not merely correct ones. Learning runs in phases. Each phase is a sequence of rounds, and each round tests every candidate once. When a phase closes, the best-scoring candidate becomes D. If even the winner scored poorly, prefetching is switched off. Learning continues while prefetching is off, so a later phase can switch it back on.

Top module: `timely_offset_pf`

## Requirements
- R1: A prefetch request (`pf_valid` high for one cycle, one cycle after the access) is made only for an access with `acc_valid` high and either `acc_miss` or `acc_pf_hit` high. Any other access makes no request and does not take part in learning.
- R2: The requested line is X+D. Line bits [5:0] are the in-page index. The request is dropped when index+D exceeds 63, and bits [25:6] of the request equal those of X.
- R3: After reset, D is 1, prefetching is on, every score is zero, the table is empty, and no request is pending.
- R4: The table has 256 entries. It is indexed by line bits [7:0] XOR bits [15:8] and holds a valid flag and a 12-bit tag taken from line bits [19:8]. A lookup hits when the entry is valid and the tags match. A write made by a fill in the same cycle is not visible to that cycle's lookup.
- R5: While prefetching is on, only a fill with `fill_pf` high writes, and it stores Y−D, skipped when D exceeds the in-page index of Y. While prefetching is off, every fill writes Y itself.
- R6: The candidates are the 52 integers from 1 to 256 that have no prime factor other than 2, 3 or 5, in ascending order. Each eligible access tests the next candidate, wrapping from the 52nd back to the first. A candidate larger than the in-page index of X never hits.
- R7: A hit adds one to the tested candidate's 5-bit score, which saturates at 31. The winner is the highest score, and on a tie the candidate that first reached that value wins.
- R8: A phase ends at the end of a round if a score is 31 or if that round is the 100th. The winner then becomes D from the next cycle on, and all scores and the round count restart from zero.
- R9: If the winning score is 1 or less, prefetching turns off and no requests are made. Scoring continues, and a later phase whose winner scores 2 or more turns prefetching back on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | A cache read access is presented |
| acc_line | input | 26 | Line address of the access |
| acc_miss | input | 1 | The access missed |
| acc_pf_hit | input | 1 | The access hit a line whose prefetch bit is set |
| fill_valid | input | 1 | A line is being filled into the cache |
| fill_line | input | 26 | Line address of the fill |
| fill_pf | input | 1 | The filled line was prefetched |
| pf_valid | output | 1 | Prefetch request strobe |
| pf_line | output | 26 | Line address of the prefetch request |

## Verification
The hardest situation to reach from the ports is the switch from prefetching off back to on. It needs one full phase that ends with no useful score, followed by a phase in which the demand-fill writes of off mode build up scores of 2 or more. The stimulus first forces a phase with no hits by sending accesses only at in-page index 0, where every test borrows out of the page. It then runs a sequential stream whose demand fills arrive two cycles after each access, until one candidate reaches 31 and requests reappear. Around these phases, random traffic in a narrow address window mixes prefetched and demand fills, collisions with same-cycle lookups, and page-edge indices. All of it is compared cycle by cycle with a model kept in the bench.

// File: rtl/tof_pkg.sv
package tof_pkg;

   // True when v has no prime factor other than 2, 3 or 5.
   function automatic bit is_smooth(input int v);
      int r;
      r = v;
      if (r < 1) return 1'b0;
      while (r % 2 == 0) r = r / 2;
      while (r % 3 == 0) r = r / 3;
      while (r % 5 == 0) r = r / 5;
      return (r == 1);
   endfunction

   // Number of smooth integers in 1..max_v.
   function automatic int smooth_count(input int max_v);
      int n;
      n = 0;
      for (int v = 1; v <= max_v; v++) begin
         if (is_smooth(v)) n++;
      end
      return n;
   endfunction

   // The k-th (from zero) smooth integer in ascending order.
   function automatic int smooth_nth(input int max_v, input int k);
      int n;
      n = 0;
      for (int v = 1; v <= max_v; v++) begin
         if (is_smooth(v)) begin
            if (n == k) return v;
            n++;
         end
      end
      return 0;
   endfunction

endpackage

// File: rtl/tof_offset_rom.sv
module tof_offset_rom #(
   parameter int MAX_OFF = 256,
   parameter int NUM_OFF = 52,
   parameter int OFF_W   = 9,
   parameter int SEL_W   = 6
) (
   input  logic [SEL_W-1:0] sel,
   output logic [OFF_W-1:0] off
);

   logic [OFF_W-1:0] tab [NUM_OFF];

   for (genvar g = 0; g < NUM_OFF; g++) begin : g_ent
      localparam int VAL = tof_pkg::smooth_nth(MAX_OFF, g);
      assign tab[g] = OFF_W'(VAL);
   end

   always_comb begin
      off = '0;
      for (int i = 0; i < NUM_OFF; i++) begin
         if (sel == SEL_W'(i)) off = tab[i];
      end
   end

endmodule

// File: rtl/tof_rr_table.sv
module tof_rr_table #(
   parameter  int IDX_W = 8,
   parameter  int TAG_W = 12,
   localparam int KEY_W = IDX_W + TAG_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [KEY_W-1:0] wr_key,
   input  logic [KEY_W-1:0] rd_key,
   output logic             rd_hit
);

   localparam int DEPTH = 1 << IDX_W;

   logic [DEPTH-1:0] valid_q;
   logic [TAG_W-1:0] tag_q [DEPTH];

   logic [IDX_W-1:0] w_idx, r_idx;
   logic [TAG_W-1:0] w_tag, r_tag;

   assign w_idx = wr_key[IDX_W-1:0] ^ wr_key[2*IDX_W-1:IDX_W];
   assign r_idx = rd_key[IDX_W-1:0] ^ rd_key[2*IDX_W-1:IDX_W];
   assign w_tag = wr_key[KEY_W-1:IDX_W];
   assign r_tag = rd_key[KEY_W-1:IDX_W];

   always_ff @(posedge clk) begin
      if (!rst_n) valid_q <= '0;
      else if (wr_en) valid_q[w_idx] <= 1'b1;
   end

   always_ff @(posedge clk) begin
      if (wr_en) tag_q[w_idx] <= w_tag;
   end

   assign rd_hit = valid_q[r_idx] && (tag_q[r_idx] == r_tag);

endmodule

// File: rtl/tof_learner.sv
module tof_learner #(
   parameter int NUM_OFF   = 52,
   parameter int SEL_W     = 6,
   parameter int SCORE_W   = 5,
   parameter int ROUND_MAX = 100,
   parameter int RND_W     = 7
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               test_en,
   input  logic               test_hit,
   output logic [SEL_W-1:0]   test_idx,
   output logic [RND_W-1:0]   round_cnt,
   output logic [SCORE_W-1:0] best_score,
   output logic [SEL_W-1:0]   win_idx,
   output logic [SCORE_W-1:0] win_score,
   output logic               phase_end
);

   localparam logic [SCORE_W-1:0] S_MAX    = '1;
   localparam logic [SEL_W-1:0]   SEL_LAST = SEL_W'(NUM_OFF - 1);
   localparam logic [RND_W-1:0]   RND_LAST = RND_W'(ROUND_MAX - 1);

   logic [SCORE_W-1:0] score_q [NUM_OFF];
   logic [SEL_W-1:0]   idx_q, best_idx_q;
   logic [RND_W-1:0]   round_q;
   logic [SCORE_W-1:0] best_q;

   logic [SCORE_W-1:0] cur, bumped;
   logic               bump, take, round_end;

   always_comb begin
      cur = '0;
      for (int i = 0; i < NUM_OFF; i++) begin
         if (idx_q == SEL_W'(i)) cur = score_q[i];
      end
   end

   assign bump      = test_en && test_hit && (cur != S_MAX);
   assign bumped    = cur + 1'b1;
   assign take      = bump && (bumped > best_q);
   assign win_score = take ? bumped : best_q;
   assign win_idx   = take ? idx_q  : best_idx_q;
   assign round_end = test_en && (idx_q == SEL_LAST);
   assign phase_end = round_end && ((win_score == S_MAX) || (round_q == RND_LAST));

   for (genvar g = 0; g < NUM_OFF; g++) begin : g_score
      logic [SCORE_W-1:0] r;
      always_ff @(posedge clk) begin
         if (!rst_n)                               r <= '0;
         else if (phase_end)                       r <= '0;
         else if (bump && idx_q == SEL_W'(g))      r <= bumped;
      end
      assign score_q[g] = r;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         idx_q      <= '0;
         round_q    <= '0;
         best_q     <= '0;
         best_idx_q <= '0;
      end else if (test_en) begin
         if (phase_end) begin
            idx_q      <= '0;
            round_q    <= '0;
            best_q     <= '0;
            best_idx_q <= '0;
         end else begin
            best_q     <= win_score;
            best_idx_q <= win_idx;
            if (round_end) begin
               idx_q   <= '0;
               round_q <= round_q + 1'b1;
            end else begin
               idx_q <= idx_q + 1'b1;
            end
         end
      end
   end

   assign test_idx   = idx_q;
   assign round_cnt  = round_q;
   assign best_score = best_q;

endmodule

// File: rtl/timely_offset_pf.sv
module timely_offset_pf #(
   parameter int LINE_W    = 26,
   parameter int PG_W      = 6,
   parameter int RR_IDX_W  = 8,
   parameter int RR_TAG_W  = 12,
   parameter int SCORE_W   = 5,
   parameter int ROUND_MAX = 100,
   parameter int MAX_OFF   = 256,
   parameter int LOW_SCORE = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              acc_valid,
   input  logic [LINE_W-1:0] acc_line,
   input  logic              acc_miss,
   input  logic              acc_pf_hit,
   input  logic              fill_valid,
   input  logic [LINE_W-1:0] fill_line,
   input  logic              fill_pf,
   output logic              pf_valid,
   output logic [LINE_W-1:0] pf_line
);

   localparam int KEY_W   = RR_IDX_W + RR_TAG_W;
   localparam int OFF_W   = $clog2(MAX_OFF + 1);
   localparam int NUM_OFF = tof_pkg::smooth_count(MAX_OFF);
   localparam int SEL_W   = $clog2(NUM_OFF);
   localparam int RND_W   = $clog2(ROUND_MAX + 1);
   localparam int SUM_W   = ((OFF_W > PG_W) ? OFF_W : PG_W) + 1;
   localparam logic [SUM_W-1:0] PAGE_LINES = SUM_W'(1 << PG_W);

   if (RR_TAG_W < RR_IDX_W) begin : g_chk_tag
      $error("tag must be at least as wide as the index");
   end
   if (LINE_W < KEY_W || KEY_W <= PG_W) begin : g_chk_line
      $error("line width must cover the table key, which must exceed the page index");
   end
   if (OFF_W < PG_W || NUM_OFF < 2) begin : g_chk_off
      $error("offset list too small for the page");
   end
   if (LOW_SCORE >= (1 << SCORE_W) - 1) begin : g_chk_low
      $error("throttle threshold must be below the saturated score");
   end

   logic [OFF_W-1:0]   off_q;
   logic               pf_on_q;

   logic               elig, fwd_ok, t_ok, f_ok, rd_raw, test_hit, wr_en;
   logic [PG_W-1:0]    acc_lo, pf_lo, t_lo, f_lo, f_base;
   logic [KEY_W-1:0]   rd_key, wr_key;
   logic [OFF_W-1:0]   test_off, win_off;
   logic [SEL_W-1:0]   test_idx, win_idx;
   logic [RND_W-1:0]   round_cnt;
   logic [SCORE_W-1:0] best_score, win_score;
   logic               phase_end;

   assign elig   = acc_valid && (acc_miss || acc_pf_hit);
   assign acc_lo = acc_line[PG_W-1:0];
   assign f_lo   = fill_line[PG_W-1:0];

   // forward adder: page index plus current offset, carry means page crossing
   assign fwd_ok = (SUM_W'(acc_lo) + SUM_W'(off_q)) < PAGE_LINES;
   assign pf_lo  = acc_lo + off_q[PG_W-1:0];

   // test adder: X minus candidate, borrow means no hit
   assign t_ok   = SUM_W'(acc_lo) >= SUM_W'(test_off);
   assign t_lo   = acc_lo - test_off[PG_W-1:0];
   assign rd_key = {acc_line[KEY_W-1:PG_W], t_lo};

   // fill adder: base of a completed prefetch
   assign f_ok   = SUM_W'(f_lo) >= SUM_W'(off_q);
   assign f_base = f_lo - off_q[PG_W-1:0];

   always_comb begin
      if (pf_on_q) begin
         wr_en  = fill_valid && fill_pf && f_ok;
         wr_key = {fill_line[KEY_W-1:PG_W], f_base};
      end else begin
         wr_en  = fill_valid;
         wr_key = fill_line[KEY_W-1:0];
      end
   end

   tof_offset_rom #(
      .MAX_OFF(MAX_OFF), .NUM_OFF(NUM_OFF), .OFF_W(OFF_W), .SEL_W(SEL_W)
   ) u_rom_test (
      .sel(test_idx), .off(test_off)
   );

   tof_offset_rom #(
      .MAX_OFF(MAX_OFF), .NUM_OFF(NUM_OFF), .OFF_W(OFF_W), .SEL_W(SEL_W)
   ) u_rom_win (
      .sel(win_idx), .off(win_off)
   );

   tof_rr_table #(
      .IDX_W(RR_IDX_W), .TAG_W(RR_TAG_W)
   ) u_rr (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_en), .wr_key(wr_key),
      .rd_key(rd_key), .rd_hit(rd_raw)
   );

   assign test_hit = rd_raw && t_ok;

   tof_learner #(
      .NUM_OFF(NUM_OFF), .SEL_W(SEL_W), .SCORE_W(SCORE_W),
      .ROUND_MAX(ROUND_MAX), .RND_W(RND_W)
   ) u_learn (
      .clk(clk), .rst_n(rst_n),
      .test_en(elig), .test_hit(test_hit),
      .test_idx(test_idx), .round_cnt(round_cnt), .best_score(best_score),
      .win_idx(win_idx), .win_score(win_score), .phase_end(phase_end)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         off_q   <= OFF_W'(1);
         pf_on_q <= 1'b1;
      end else if (phase_end) begin
         off_q   <= win_off;
         pf_on_q <= win_score > SCORE_W'(LOW_SCORE);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pf_valid <= 1'b0;
         pf_line  <= '0;
      end else begin
         pf_valid <= elig && pf_on_q && fwd_ok;
         if (elig) pf_line <= {acc_line[LINE_W-1:PG_W], pf_lo};
      end
   end

endmodule

// File: rtl/tof_chk.sv
module tof_chk #(
   parameter int LINE_W    = 26,
   parameter int PG_W      = 6,
   parameter int SEL_W     = 6,
   parameter int RND_W     = 7,
   parameter int SCORE_W   = 5,
   parameter int NUM_OFF   = 52,
   parameter int ROUND_MAX = 100
) (
   input logic               clk,
   input logic               rst_n,
   input logic               acc_valid,
   input logic               acc_miss,
   input logic               acc_pf_hit,
   input logic [LINE_W-1:0]  acc_line,
   input logic               fill_valid,
   input logic [LINE_W-1:0]  fill_line,
   input logic               pf_valid,
   input logic [LINE_W-1:0]  pf_line,
   input logic               pf_on_q,
   input logic [SEL_W-1:0]   test_idx,
   input logic [RND_W-1:0]   round_cnt,
   input logic [SCORE_W-1:0] best_score,
   input logic               phase_end
);

   logic elig;
   assign elig = acc_valid && (acc_miss || acc_pf_hit);

   AST_PF_ELIGIBLE: assert property (@(posedge clk) disable iff (!rst_n)
      pf_valid |-> $past(elig)); // R1

   AST_PF_SAME_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
      pf_valid |-> pf_line[LINE_W-1:PG_W] == $past(acc_line[LINE_W-1:PG_W])); // R2

   AST_PF_AHEAD: assert property (@(posedge clk) disable iff (!rst_n)
      pf_valid |-> pf_line[PG_W-1:0] > $past(acc_line[PG_W-1:0])); // R2

   AST_FILL_KNOWN: assert property (@(posedge clk) disable iff (!rst_n)
      fill_valid |-> !$isunknown(fill_line)); // R5

   AST_TEST_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      test_idx < SEL_W'(NUM_OFF)); // R6

   AST_TEST_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (elig && test_idx != SEL_W'(NUM_OFF - 1)) |=> test_idx == SEL_W'($past(test_idx) + 1'b1)); // R6

   AST_TEST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !elig |=> $stable(test_idx)); // R6

   AST_BEST_MONO: assert property (@(posedge clk) disable iff (!rst_n)
      !phase_end |=> best_score >= $past(best_score)); // R7

   AST_ROUND_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      round_cnt < RND_W'(ROUND_MAX)); // R8

   AST_PHASE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      phase_end |=> (best_score == '0 && round_cnt == '0 && test_idx == '0)); // R8

   AST_OFF_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      !pf_on_q |=> !pf_valid); // R9

endmodule

bind timely_offset_pf tof_chk #(
   .LINE_W(LINE_W), .PG_W(PG_W), .SEL_W(SEL_W), .RND_W(RND_W),
   .SCORE_W(SCORE_W), .NUM_OFF(NUM_OFF), .ROUND_MAX(ROUND_MAX)
) u_chk (
   .clk(clk), .rst_n(rst_n),
   .acc_valid(acc_valid), .acc_miss(acc_miss), .acc_pf_hit(acc_pf_hit),
   .acc_line(acc_line), .fill_valid(fill_valid), .fill_line(fill_line),
   .pf_valid(pf_valid), .pf_line(pf_line), .pf_on_q(pf_on_q),
   .test_idx(test_idx), .round_cnt(round_cnt), .best_score(best_score),
   .phase_end(phase_end)
);

// File: tb/sim_timely_offset_pf.sv
module sim_timely_offset_pf;

   localparam int CLK_PERIOD = 10;
   localparam int LW         = 26;
   localparam int NOFF       = 52;
   localparam int RMAX       = 100;
   localparam int SMAX       = 31;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          acc_valid = 1'b0, acc_miss = 1'b0, acc_pf_hit = 1'b0;
   logic [LW-1:0] acc_line = '0;
   logic          fill_valid = 1'b0, fill_pf = 1'b0;
   logic [LW-1:0] fill_line = '0;
   logic          pf_valid;
   logic [LW-1:0] pf_line;

   always #(CLK_PERIOD/2) clk = ~clk;

   timely_offset_pf u0 (
      .clk(clk), .rst_n(rst_n),
      .acc_valid(acc_valid), .acc_line(acc_line),
      .acc_miss(acc_miss), .acc_pf_hit(acc_pf_hit),
      .fill_valid(fill_valid), .fill_line(fill_line), .fill_pf(fill_pf),
      .pf_valid(pf_valid), .pf_line(pf_line)
   );

   int checks = 0, failures = 0;
   bit done = 0;

   // ---------------- bench model ----------------
   int         offl [NOFF];
   int         sc [NOFF];
   bit         rr_v [256];
   logic [11:0] rr_t [256];
   int         m_d, m_idx, m_round, m_best_s, m_best_i;
   bit         m_on;
   bit         pend = 0, exp_v;
   logic [LW-1:0] exp_l;
   string      exp_rq;

   function automatic bit smooth(int v);
      int r = v;
      while (r % 2 == 0) r /= 2;
      while (r % 3 == 0) r /= 3;
      while (r % 5 == 0) r /= 5;
      return r == 1;
   endfunction

   function automatic int hx(logic [LW-1:0] l);
      return int'(l[7:0] ^ l[15:8]);
   endfunction

   task automatic model_reset();
      int n = 0;
      for (int v = 1; v <= 256; v++) if (smooth(v)) begin offl[n] = v; n++; end
      for (int i = 0; i < NOFF; i++) sc[i] = 0;
      for (int i = 0; i < 256; i++) rr_v[i] = 0;
      m_d = 1; m_on = 1; m_idx = 0; m_round = 0; m_best_s = 0; m_best_i = 0;
   endtask

   task automatic model_step(bit av, logic [LW-1:0] a, bit mi, bit ph,
                             bit fv, logic [LW-1:0] y, bit fp);
      bit elig, hit, wv, any31;
      int lo, d, yl, h;
      logic [LW-1:0] t, wl;
      elig = av && (mi || ph);
      lo = int'(a[5:0]);
      exp_v = elig && m_on && (lo + m_d < 64);
      exp_l = {a[LW-1:6], 6'(lo + m_d)};
      hit = 0;
      d = offl[m_idx];
      if (elig && lo >= d) begin
         t = a - LW'(d);
         h = hx(t);
         hit = rr_v[h] && (rr_t[h] == t[19:8]);
      end
      yl = int'(y[5:0]);
      wv = 0; wl = y;
      if (fv) begin
         if (!m_on) wv = 1;
         else if (fp && yl >= m_d) begin wv = 1; wl = y - LW'(m_d); end
      end
      if (elig) begin
         if (hit && sc[m_idx] < SMAX) begin
            sc[m_idx]++;
            if (sc[m_idx] > m_best_s) begin m_best_s = sc[m_idx]; m_best_i = m_idx; end
         end
         if (m_idx == NOFF - 1) begin
            m_round++;
            any31 = 0;
            for (int i = 0; i < NOFF; i++) if (sc[i] == SMAX) any31 = 1;
            if (any31 || m_round == RMAX) begin
               m_d = offl[m_best_i];
               m_on = (m_best_s > 1);
               for (int i = 0; i < NOFF; i++) sc[i] = 0;
               m_round = 0; m_best_s = 0; m_best_i = 0;
            end
            m_idx = 0;
         end else m_idx++;
      end
      if (wv) begin
         rr_v[hx(wl)] = 1;
         rr_t[hx(wl)] = wl[19:8];
      end
   endtask

   task automatic compare();
      if (pend) begin
         checks++;
         if (pf_valid !== exp_v || (exp_v && pf_line !== exp_l)) begin
            failures++;
            $display("FAIL %s: pf_valid=%0b pf_line=%h expected pf_valid=%0b pf_line=%h",
                     exp_rq, pf_valid, pf_line, exp_v, exp_l);
         end
      end
   endtask

   task automatic cyc(bit av, logic [LW-1:0] a, bit mi, bit ph,
                      bit fv, logic [LW-1:0] y, bit fp, string rq);
      @(negedge clk);
      compare();
      acc_valid = av; acc_line = a; acc_miss = mi; acc_pf_hit = ph;
      fill_valid = fv; fill_line = y; fill_pf = fp;
      model_step(av, a, mi, ph, fv, y, fp);
      exp_rq = rq;
      pend = 1;
   endtask

   function automatic logic [LW-1:0] rline();
      return LW'($urandom);
   endfunction

   // ---------------- stimulus ----------------
   logic [LW-1:0] ring_l [6];
   bit            ring_v [6];

   initial begin
      logic [LW-1:0] base, x, p1, p2;
      void'($urandom(32'd4242));
      model_reset();
      repeat (3) @(posedge clk);
      @(negedge clk);
      checks++;
      if (pf_valid !== 1'b0) begin
         failures++;
         $display("FAIL R3: pf_valid=%0b during reset expected 0", pf_valid);
      end
      rst_n = 1'b1;

      // R3: reset offset is 1 and prefetching is on
      base = {rline()} & ~LW'(63);
      cyc(1, base, 1, 0, 0, '0, 0, "R3");
      // R1: eligibility
      cyc(1, base + 5, 0, 0, 0, '0, 0, "R1");   // plain hit: no request
      cyc(0, base + 6, 1, 0, 0, '0, 0, "R1");   // not valid
      cyc(1, base + 7, 0, 1, 0, '0, 0, "R1");   // prefetched hit: request
      cyc(1, base + 8, 1, 1, 0, '0, 0, "R1");
      // R2: page edge
      cyc(1, base | LW'(63), 1, 0, 0, '0, 0, "R2");
      cyc(1, base | LW'(62), 1, 0, 0, '0, 0, "R2");
      cyc(1, {6'h2A, 14'h1234, 6'd62}, 1, 0, 0, '0, 0, "R2");

      // R6/R7: sequential stream with prefetched fills 6 cycles late
      for (int i = 0; i < 6; i++) ring_v[i] = 0;
      base = rline();
      for (int k = 0; k < 3000; k++) begin
         int s = k % 6;
         cyc(1, base + LW'(k), 1, 0, ring_v[s], ring_l[s], 1, (k < 1500) ? "R6" : "R7");
         ring_v[s] = exp_v; ring_l[s] = exp_l;
      end

      // R9: accesses at page index 0 only, so no test can hit; phases close low
      for (int k = 0; k < 11000; k++)
         cyc(1, rline() & ~LW'(63), 1, 0, 0, '0, 0, "R9");
      cyc(1, base & ~LW'(63), 1, 0, 0, '0, 0, "R9");

      // R8/R9: off mode, demand fills of every line re-enable prefetching
      base = rline();
      p1 = '0; p2 = '0;
      for (int k = 0; k < 2500; k++) begin
         x = base + LW'(k);
         cyc(1, x, 1, 0, (k >= 2), p2, 0, "R8");
         p2 = p1; p1 = x;
      end
      cyc(1, base & ~LW'(63), 1, 0, 0, '0, 0, "R9");

      // R4/R5: random traffic in a narrow window, collisions included
      base = rline() & ~LW'(1023);
      for (int k = 0; k < 8000; k++) begin
         bit av = ($urandom % 8) != 0;
         bit mi = ($urandom % 2) != 0;
         bit ph = ($urandom % 3) == 0;
         bit fv = ($urandom % 2) != 0;
         bit fp = ($urandom % 4) != 0;
         logic [LW-1:0] a = base + LW'($urandom % 1024);
         logic [LW-1:0] y = ($urandom % 4 == 0) ? a : base + LW'($urandom % 1024);
         cyc(av, a, mi, ph, fv, y, fp, (k < 4000) ? "R4" : "R5");
      end

      @(negedge clk);
      compare();
      acc_valid = 0; fill_valid = 0;
      if (!done) begin
         done = 1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1;
         checks++;
         failures++;
         $display("FAIL watchdog: run did not finish, expected completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule